// File: doc/BRIEF.md
# Floating-Point Coprocessor Resource-Hazard Stall Unit

This block sits at the issue stage of a floating-point coprocessor that has three execution pipelines: a multiply-accumulate pipe (FMAC), a divide/square-root pipe (DS) and a load/store pipe (LS). Each cycle it looks at one decoded instruction descriptor. It holds the instruction with `stall` while the pipeline that the instruction needs is still occupied. When that pipeline is free it raises `issue` and books how many further cycles the pipeline stays occupied.

Occupancy is kept as one down-counter per pipeline. Each counter is loaded on issue and counts down to zero. The stall decision is combinational from the three counters, the incoming descriptor and the memory-wait input. Register data dependencies, the arithmetic and the memory side are outside this block.

Descriptor encoding: `op_cls` is 0 for a data transfer and 1 for arithmetic. `op_kind` is 00 for add-type, 01 for multiply/multiply-accumulate, 10 for divide and 11 for square root; 1x means the DS pipe. `op_dbl` selects double precision. `op_vlen_m1` is the vector length minus one (1 to 8 elements). `op_nxfer_m1` is the register count of a transfer minus one (1 to 16).

Top module: `fphz_stall_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `fmac_busy`, `ds_busy` and `ls_busy`, including in the middle of a long divide. In the first cycle after reset, a valid descriptor of any kind issues at once.
- R2: `stall` is low whenever `valid` is low. `issue` equals `valid && !stall`, so `issue` and `stall` are never high together.
- R3: A scalar add-type op, or a scalar single-precision multiply, lets the next arithmetic op issue in the following cycle. A scalar double-precision multiply (`op_kind`=01, `op_dbl`=1) makes an arithmetic op presented in the next cycle stall for exactly one cycle.
- R4: A short-vector FMAC op of L elements occupies the FMAC pipe for L cycles, or 2L cycles for a double multiply. A following arithmetic op presented back to back stalls L-1 or 2L-1 cycles.
- R5: After a scalar single-precision divide or square root issues, a DS op presented in the next cycle stalls 15 cycles. After a double-precision one it stalls 29 cycles.
- R6: A short-vector divide/sqrt of L elements with per-element period P (16 single, 30 double) claims FMAC at the start of every element. A following non-DS arithmetic op stalls (L-1)*P cycles, and the DS pipe stays occupied L*P-1 cycles after issue.
- R7: An FMAC op (`op_kind`=0x) is not held by a busy DS pipe.
- R8: Transfers never stall on FMAC or DS occupancy, and arithmetic ops never stall on LS occupancy.
- R9: A transfer of N registers executes N beats, one per cycle from the cycle after issue. The next transfer issues in the cycle the final beat executes, so a back-to-back follower stalls N-1 cycles.
- R10: While an LS beat is executing, `mem_wait` holds that beat and adds one stall cycle per wait cycle to any waiting transfer. With the LS pipe idle, `mem_wait` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Descriptor present this cycle |
| op_cls | input | 1 | 0 transfer, 1 arithmetic |
| op_kind | input | 2 | 00 add, 01 mul, 10 div, 11 sqrt |
| op_dbl | input | 1 | Double precision |
| op_vlen_m1 | input | 3 | Vector length minus one |
| op_nxfer_m1 | input | 4 | Transfer register count minus one |
| mem_wait | input | 1 | Memory not ready for the current LS beat |
| issue | output | 1 | Descriptor consumed this cycle |
| stall | output | 1 | Descriptor held this cycle |
| fmac_busy | output | 1 | FMAC pipe occupied |
| ds_busy | output | 1 | DS pipe occupied |
| ls_busy | output | 1 | LS pipe has beats outstanding |

## Verification
Two functions can meet in one cycle on the LS pipe. The final beat of a multi-register transfer can retire in the same cycle that a waiting transfer issues and reloads the same counter, and a memory wait can land on that same final beat. The bench provokes both: it presents a single load directly behind multi-register loads, once with no waits and once with `mem_wait` held over the leading beats. It judges each case by the exact number of stall cycles before `issue` rises, which must be N-1 plus one cycle per wait. A second overlap, an FMAC op issuing while a divide holds DS, is provoked by back-to-back divide then add/multiply and judged by a zero stall count while `ds_busy` stays high.

// File: rtl/fphz_pkg.sv
package fphz_pkg;

    localparam int VLEN_W = 3;
    localparam int XCNT_W = 4;

    typedef enum logic {
        CLS_XFER  = 1'b0,
        CLS_ARITH = 1'b1
    } op_cls_e;

    typedef enum logic [1:0] {
        K_ADD  = 2'b00,
        K_MUL  = 2'b01,
        K_DIV  = 2'b10,
        K_SQRT = 2'b11
    } op_kind_e;

    typedef struct packed {
        op_cls_e            cls;
        op_kind_e           kind;
        logic               dbl;
        logic [VLEN_W-1:0]  vlen_m1;
        logic [XCNT_W-1:0]  nxfer_m1;
    } fphz_desc_t;

    function automatic logic kind_on_ds(op_kind_e k);
        return k[1];
    endfunction

endpackage

// File: rtl/fphz_busy_ctr.sv
module fphz_busy_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         hold,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0 && !hold) begin
            cnt <= cnt - W'(1);
        end
    end

endmodule

// File: rtl/fphz_occ_calc.sv
module fphz_occ_calc
    import fphz_pkg::*;
#(
    parameter int SP_STALL = 15,
    parameter int DP_STALL = 29,
    parameter int MAC_W    = 8,
    parameter int DS_W     = 8,
    parameter int LS_W     = 5
) (
    input  op_kind_e            kind,
    input  logic                dbl,
    input  logic [VLEN_W-1:0]   vlen_m1,
    input  logic [XCNT_W-1:0]   nxfer_m1,
    output logic [MAC_W-1:0]    mac_ld,
    output logic [DS_W-1:0]     ds_ld,
    output logic [LS_W-1:0]     ls_ld
);

    int elems;
    int period;
    int mac_i;
    int ds_i;
    int ls_i;

    always_comb begin
        elems  = int'(vlen_m1) + 1;
        period = dbl ? (DP_STALL + 1) : (SP_STALL + 1);
        if (kind_on_ds(kind)) begin
            // FMAC is claimed at the start of each element; the last start releases it
            mac_i = (elems - 1) * period;
            ds_i  = elems * period - 1;
        end else begin
            mac_i = (kind == K_MUL && dbl) ? (2 * elems - 1) : (elems - 1);
            ds_i  = 0;
        end
        ls_i = int'(nxfer_m1) + 1;
    end

    assign mac_ld = MAC_W'(mac_i);
    assign ds_ld  = DS_W'(ds_i);
    assign ls_ld  = LS_W'(ls_i);

endmodule

// File: rtl/fphz_stall_unit.sv
module fphz_stall_unit
    import fphz_pkg::*;
#(
    parameter int SP_DIV_STALL = 15,
    parameter int DP_DIV_STALL = 29
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              op_cls,
    input  logic [1:0]        op_kind,
    input  logic              op_dbl,
    input  logic [VLEN_W-1:0] op_vlen_m1,
    input  logic [XCNT_W-1:0] op_nxfer_m1,
    input  logic              mem_wait,
    output logic              issue,
    output logic              stall,
    output logic              fmac_busy,
    output logic              ds_busy,
    output logic              ls_busy
);

    localparam int MAX_VLEN = 1 << VLEN_W;
    localparam int MAX_XFER = 1 << XCNT_W;
    localparam int DP_PER   = DP_DIV_STALL + 1;
    localparam int MAC_VDIV = (MAX_VLEN - 1) * DP_PER;
    localparam int MAC_VMUL = 2 * MAX_VLEN - 1;
    localparam int MAC_MAX  = (MAC_VDIV > MAC_VMUL) ? MAC_VDIV : MAC_VMUL;
    localparam int DS_MAX   = MAX_VLEN * DP_PER - 1;
    localparam int MAC_W    = $clog2(MAC_MAX + 1);
    localparam int DS_W     = $clog2(DS_MAX + 1);
    localparam int LS_W     = $clog2(MAX_XFER + 1);

    fphz_desc_t desc;
    logic [MAC_W-1:0] mac_cnt, mac_ld;
    logic [DS_W-1:0]  ds_cnt, ds_ld;
    logic [LS_W-1:0]  ls_cnt, ls_ld;
    logic is_arith, needs_ds, mac_hz, ds_hz, ls_hz;

    always_comb begin
        desc.cls      = op_cls_e'(op_cls);
        desc.kind     = op_kind_e'(op_kind);
        desc.dbl      = op_dbl;
        desc.vlen_m1  = op_vlen_m1;
        desc.nxfer_m1 = op_nxfer_m1;
    end

    fphz_occ_calc #(
        .SP_STALL (SP_DIV_STALL),
        .DP_STALL (DP_DIV_STALL),
        .MAC_W    (MAC_W),
        .DS_W     (DS_W),
        .LS_W     (LS_W)
    ) u_occ (
        .kind     (desc.kind),
        .dbl      (desc.dbl),
        .vlen_m1  (desc.vlen_m1),
        .nxfer_m1 (desc.nxfer_m1),
        .mac_ld   (mac_ld),
        .ds_ld    (ds_ld),
        .ls_ld    (ls_ld)
    );

    assign is_arith = (desc.cls == CLS_ARITH);
    assign needs_ds = is_arith && kind_on_ds(desc.kind);
    assign mac_hz   = (mac_cnt != '0);
    assign ds_hz    = needs_ds && (ds_cnt != '0);
    // a follower may enter while the leader's last beat completes
    assign ls_hz    = (ls_cnt > LS_W'(1)) || (ls_cnt == LS_W'(1) && mem_wait);

    assign stall = valid && (is_arith ? (mac_hz || ds_hz) : ls_hz);
    assign issue = valid && !stall;

    fphz_busy_ctr #(.W(MAC_W)) u_mac_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (issue && is_arith),
        .load_val (mac_ld),
        .hold     (1'b0),
        .cnt      (mac_cnt)
    );

    fphz_busy_ctr #(.W(DS_W)) u_ds_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (issue && needs_ds),
        .load_val (ds_ld),
        .hold     (1'b0),
        .cnt      (ds_cnt)
    );

    fphz_busy_ctr #(.W(LS_W)) u_ls_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (issue && !is_arith),
        .load_val (ls_ld),
        .hold     (mem_wait),
        .cnt      (ls_cnt)
    );

    assign fmac_busy = mac_hz;
    assign ds_busy   = (ds_cnt != '0);
    assign ls_busy   = (ls_cnt != '0);

endmodule

// File: rtl/fphz_stall_chk.sv
module fphz_stall_chk (
    input logic       clk,
    input logic       rst,
    input logic       valid,
    input logic       op_cls,
    input logic [1:0] op_kind,
    input logic       op_dbl,
    input logic [2:0] op_vlen_m1,
    input logic       mem_wait,
    input logic       issue,
    input logic       stall,
    input logic       fmac_busy,
    input logic       ds_busy,
    input logic       ls_busy
);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (!stall && !issue));

    assert_issue_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(issue && stall));

    assert_dmul_two_R3: assert property (@(posedge clk) disable iff (rst)
        (issue && op_cls && op_kind == 2'b01 && op_dbl && op_vlen_m1 == 3'd0)
        |=> fmac_busy ##1 !fmac_busy);

    assert_div_books_ds_R5: assert property (@(posedge clk) disable iff (rst)
        (issue && op_cls && op_kind[1]) |=> ds_busy);

    assert_fmac_free_of_ds_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && op_cls && !op_kind[1] && !fmac_busy) |-> issue);

    assert_xfer_free_of_arith_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && !op_cls && !ls_busy) |-> issue);

    assert_wait_holds_beat_R10: assert property (@(posedge clk) disable iff (rst)
        (ls_busy && mem_wait && !issue) |=> ls_busy);

endmodule

bind fphz_stall_unit fphz_stall_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid      (valid),
    .op_cls     (op_cls),
    .op_kind    (op_kind),
    .op_dbl     (op_dbl),
    .op_vlen_m1 (op_vlen_m1),
    .mem_wait   (mem_wait),
    .issue      (issue),
    .stall      (stall),
    .fmac_busy  (fmac_busy),
    .ds_busy    (ds_busy),
    .ls_busy    (ls_busy)
);

// File: tb/fphz_stall_unit_test.sv
module fphz_stall_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       valid = 1'b0;
    logic       op_cls = 1'b0;
    logic [1:0] op_kind = 2'b00;
    logic       op_dbl = 1'b0;
    logic [2:0] op_vlen_m1 = 3'd0;
    logic [3:0] op_nxfer_m1 = 4'd0;
    logic       mem_wait = 1'b0;
    logic       issue, stall, fmac_busy, ds_busy, ls_busy;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    fphz_stall_unit uut (
        .clk         (clk),
        .rst         (rst),
        .valid       (valid),
        .op_cls      (op_cls),
        .op_kind     (op_kind),
        .op_dbl      (op_dbl),
        .op_vlen_m1  (op_vlen_m1),
        .op_nxfer_m1 (op_nxfer_m1),
        .mem_wait    (mem_wait),
        .issue       (issue),
        .stall       (stall),
        .fmac_busy   (fmac_busy),
        .ds_busy     (ds_busy),
        .ls_busy     (ls_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // present a descriptor from the next negedge; count stall cycles until issue
    task automatic send(input logic cls, input logic [1:0] kind, input logic dbl,
                        input int vlen, input int nxfer, input int waits,
                        output int stalls);
        int cyc = 0;
        @(negedge clk);
        valid       = 1'b1;
        op_cls      = cls;
        op_kind     = kind;
        op_dbl      = dbl;
        op_vlen_m1  = 3'(vlen - 1);
        op_nxfer_m1 = 4'(nxfer - 1);
        stalls      = 0;
        for (int i = 0; i < 1000; i++) begin
            mem_wait = (cyc < waits);
            #1;
            if (!stall && issue) break;
            stalls++;
            cyc++;
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        valid    = 1'b0;
        mem_wait = 1'b0;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        valid = 1'b0;
        rst   = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        int s;
        do_reset();
        check("R1", "fmac_busy after reset", int'(fmac_busy), 0);
        check("R1", "ds_busy after reset", int'(ds_busy), 0);
        check("R1", "ls_busy after reset", int'(ls_busy), 0);
        send(1'b1, 2'b10, 1'b1, 1, 1, 0, s);
        check("R1", "div stalls after reset", s, 0);
        // reset in the middle of a long divide
        do_reset();
        check("R1", "ds_busy cleared mid-divide", int'(ds_busy), 0);
        send(1'b1, 2'b11, 1'b1, 1, 1, 0, s);
        check("R1", "sqrt stalls after mid reset", s, 0);
        do_reset();
    endtask

    task automatic t_valid();
        int s;
        send(1'b1, 2'b10, 1'b1, 1, 1, 0, s);
        @(negedge clk);
        valid   = 1'b0;
        op_cls  = 1'b1;
        op_kind = 2'b10;
        #1;
        check("R2", "stall with valid low", int'(stall), 0);
        check("R2", "issue with valid low", int'(issue), 0);
        valid = 1'b1;
        #1;
        check("R2", "stall with valid high, DS busy", int'(stall), 1);
        check("R2", "issue while stalled", int'(issue), 0);
        valid = 1'b0;
        do_reset();
    endtask

    task automatic t_fmac_scalar();
        int s;
        send(1'b1, 2'b01, 1'b1, 1, 1, 0, s);
        send(1'b1, 2'b00, 1'b0, 1, 1, 0, s);
        check("R3", "add after double mul stalls", s, 1);
        send(1'b1, 2'b01, 1'b0, 1, 1, 0, s);
        check("R3", "single mul after add stalls", s, 0);
        send(1'b1, 2'b00, 1'b1, 1, 1, 0, s);
        check("R3", "add after single mul stalls", s, 0);
        idle(2);
    endtask

    task automatic t_fmac_vector();
        int s;
        send(1'b1, 2'b00, 1'b0, 4, 1, 0, s);
        send(1'b1, 2'b00, 1'b0, 1, 1, 0, s);
        check("R4", "add after 4-elem vector add", s, 3);
        send(1'b1, 2'b01, 1'b1, 3, 1, 0, s);
        send(1'b1, 2'b01, 1'b0, 1, 1, 0, s);
        check("R4", "mul after 3-elem double mul vector", s, 5);
        idle(2);
    endtask

    task automatic t_div_scalar();
        int s;
        send(1'b1, 2'b10, 1'b0, 1, 1, 0, s);
        send(1'b1, 2'b11, 1'b0, 1, 1, 0, s);
        check("R5", "sqrt after single div", s, 15);
        idle(20);
        send(1'b1, 2'b11, 1'b1, 1, 1, 0, s);
        send(1'b1, 2'b10, 1'b1, 1, 1, 0, s);
        check("R5", "div after double sqrt", s, 29);
        idle(35);
    endtask

    task automatic t_div_vector();
        int s;
        send(1'b1, 2'b10, 1'b0, 3, 1, 0, s);
        #1;
        check("R6", "fmac_busy after vector div", int'(fmac_busy), 1);
        check("R6", "ds_busy after vector div", int'(ds_busy), 1);
        send(1'b1, 2'b00, 1'b0, 1, 1, 0, s);
        check("R6", "add after 3-elem single vector div", s, 32);
        // DS booked 47 cycles; add issued 33 cycles in, div presented at 34
        send(1'b1, 2'b10, 1'b0, 1, 1, 0, s);
        check("R6", "div after vector div and add", s, 14);
        idle(20);
    endtask

    task automatic t_fmac_vs_ds();
        int s;
        send(1'b1, 2'b10, 1'b1, 1, 1, 0, s);
        send(1'b1, 2'b00, 1'b1, 1, 1, 0, s);
        check("R7", "add behind double div", s, 0);
        send(1'b1, 2'b01, 1'b0, 1, 1, 0, s);
        check("R7", "mul behind double div", s, 0);
        #1;
        check("R7", "ds_busy still held", int'(ds_busy), 1);
        idle(35);
    endtask

    task automatic t_indep();
        int s;
        send(1'b0, 2'b00, 1'b0, 1, 8, 0, s);
        send(1'b1, 2'b00, 1'b0, 1, 1, 0, s);
        check("R8", "add behind 8-reg load", s, 0);
        send(1'b1, 2'b10, 1'b0, 1, 1, 0, s);
        check("R8", "div behind 8-reg load", s, 0);
        send(1'b0, 2'b00, 1'b0, 1, 1, 0, s);
        check("R8", "load behind div and 8-reg load", s, 5);
        idle(20);
    endtask

    task automatic t_ls_seq();
        int s;
        send(1'b0, 2'b00, 1'b0, 1, 2, 0, s);
        send(1'b0, 2'b00, 1'b0, 1, 1, 0, s);
        check("R9", "load after 2-reg load", s, 1);
        send(1'b0, 2'b00, 1'b0, 1, 1, 0, s);
        check("R9", "load after single load", s, 0);
        idle(3);
        send(1'b0, 2'b00, 1'b0, 1, 4, 0, s);
        send(1'b0, 2'b00, 1'b0, 1, 1, 0, s);
        check("R9", "load after 4-reg load", s, 3);
        idle(3);
    endtask

    task automatic t_mem_wait();
        int s;
        send(1'b0, 2'b00, 1'b0, 1, 3, 0, s);
        send(1'b0, 2'b00, 1'b0, 1, 1, 2, s);
        check("R10", "load after 3-reg load with 2 waits", s, 4);
        idle(4);
        check("R10", "ls_busy idle before wait test", int'(ls_busy), 0);
        send(1'b0, 2'b00, 1'b0, 1, 1, 5, s);
        check("R10", "load with wait on idle LS", s, 0);
        idle(3);
    endtask

    initial begin
        t_reset();
        t_valid();
        t_fmac_scalar();
        t_fmac_vector();
        t_div_scalar();
        t_div_vector();
        t_fmac_vs_ds();
        t_indep();
        t_ls_seq();
        t_mem_wait();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule